// File: doc/BRIEF.md
# Run-time reprogrammable FIR filter with staged coefficient bank

This block is a direct-form FIR filter with a fixed tap count. A host can replace its impulse response while the filter is running. The host writes taps one at a time into a staging bank through a simple addressed write port. A single commit pulse then copies the entire staging bank into the working bank in one clock edge. The datapath reads only the working bank, so the host can load a new response (for example, a highpass after a lowpass) while samples are still being filtered with the old one. Every output is therefore computed from exactly one coefficient set.

Samples arrive one per clock on a signed input. Every tap has its own multiplier, and the products are summed at full precision. The sum is then clamped to the signed output range and registered. From a sample entering to its output appearing, the latency is always two clock edges.

Top module: `progfir`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the staging bank, the working bank and the sample history to zero. The output reads zero on the edge after reset is sampled.
- R2: When `cw_en` is high at a clock edge, `cw_data` is stored in staging slot `cw_addr`. Slot 0 multiplies the newest sample, and slot N-1 multiplies the oldest sample.
- R3: Writes to the staging bank have no effect on the output until a commit occurs.
- R4: When `cw_commit` is high at a clock edge, every working coefficient is loaded from staging in that same edge. No output ever mixes taps from two different sets.
- R5: A full-precision sum above 32767 is output as 32767 (positive saturation).
- R6: A full-precision sum below -32768 is output as -32768 (negative saturation).
- R7: The sample presented at edge k contributes to the output that is visible after edge k+1. With a unit impulse, tap i therefore appears after edge k+1+i.
- R8: If `cw_en` and `cw_commit` are both high at the same edge, the working bank receives the staging contents as they were before that write. The write still lands in staging.
- R9: A commit at edge c first affects the output visible after edge c+1. That output is computed from the sample presented at edge c and the older samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cw_data | input | CW (16) | Coefficient value to stage, signed |
| cw_addr | input | AW (4) | Staging slot index |
| cw_en | input | 1 | Staging write strobe |
| cw_commit | input | 1 | Copy the whole staging bank into the working bank |
| x_in | input | SW (16) | Input sample, signed, one per clock |
| y_out | output | OW (16) | Filtered, saturated output, signed |

## Verification
The hardest situation to reach is a commit that lands in the middle of a busy stream. The history then holds samples that were already filtered with the old taps, and the same edge may also carry a staging write. The bench writes a full new set at random addresses while random samples keep flowing. It then commits, sometimes together with a write, and checks every output against a convolution model that tracks its own staging and working banks. Directed phases with full-scale samples and full-scale taps drive the sum past both clamp limits.

// File: rtl/progfir.sv
module progfir #(
  parameter int N  = 16,
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int OW = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [CW-1:0] cw_data,
  input  logic [AW-1:0]        cw_addr,
  input  logic                 cw_en,
  input  logic                 cw_commit,
  input  logic signed [SW-1:0] x_in,
  output logic signed [OW-1:0] y_out
);
  localparam int PW   = SW + CW;
  localparam int ACCW = PW + $clog2(N + 1);
  localparam logic signed [ACCW-1:0] YMAX = ACCW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [ACCW-1:0] YMIN = -ACCW'(64'sd1 <<< (OW - 1));

  logic [N-1:0][CW-1:0] stage_q, shadow_q;
  logic [N-1:0][SW-1:0] hist_q;
  logic signed [PW-1:0] prod [N];
  logic signed [ACCW-1:0] acc;
  logic signed [OW-1:0] y_sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      shadow_q <= '0;
      hist_q   <= '0;
      y_out    <= '0;
    end else begin
      if (cw_en && (int'(cw_addr) < N)) stage_q[cw_addr] <= cw_data;
      if (cw_commit) shadow_q <= stage_q;
      hist_q <= {hist_q[N-2:0], x_in};
      y_out  <= y_sat;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_tap
    assign prod[i] = $signed(hist_q[i]) * $signed(shadow_q[i]);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + ACCW'(prod[i]);
  end

  assign y_sat = (acc > YMAX) ? OW'(YMAX) :
                 (acc < YMIN) ? OW'(YMIN) : OW'(acc);
endmodule

// File: rtl/progfir_chk.sv
module progfir_chk #(
  parameter int N  = 16,
  parameter int CW = 16,
  parameter int OW = 16,
  parameter int AW = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cw_en,
  input logic                 cw_commit,
  input logic [AW-1:0]        cw_addr,
  input logic [CW-1:0]        cw_data,
  input logic [N-1:0][CW-1:0] stage_q,
  input logic [N-1:0][CW-1:0] shadow_q,
  input logic [OW-1:0]        y_out
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (y_out == '0 && shadow_q == '0 && stage_q == '0));

  p_stage_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cw_en && int'(cw_addr) < N) |=> stage_q[$past(cw_addr)] == $past(cw_data));

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cw_commit |=> $stable(shadow_q));

  p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
    cw_commit |=> shadow_q == $past(stage_q));

  p_zero_taps_r7: assert property (@(posedge clk) disable iff (rst)
    (shadow_q == '0) |=> y_out == '0);
endmodule

bind progfir progfir_chk #(.N(N), .CW(CW), .OW(OW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cw_en(cw_en), .cw_commit(cw_commit),
  .cw_addr(cw_addr), .cw_data(cw_data), .stage_q(stage_q),
  .shadow_q(shadow_q), .y_out(y_out)
);

// File: tb/test_progfir.sv
`timescale 1ns/1ps
module test_progfir;
  localparam int N = 16;
  localparam int AW = 4;

  logic clk = 0, rst = 1;
  logic signed [15:0] cw_data = 0, x_in = 0;
  logic [AW-1:0] cw_addr = 0;
  logic cw_en = 0, cw_commit = 0;
  logic signed [15:0] y_out;

  int checks = 0, failures = 0;
  string tag = "R1";
  longint stg_m [N], shd_m [N], hist_m [N];
  longint exp_y;
  bit done = 0;

  always #2.5 clk = ~clk;

  progfir #(.N(N)) i_progfir (
    .clk(clk), .rst(rst), .cw_data(cw_data), .cw_addr(cw_addr),
    .cw_en(cw_en), .cw_commit(cw_commit), .x_in(x_in), .y_out(y_out));

  function automatic longint clamp16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint conv();
    longint s = 0;
    for (int i = 0; i < N; i++) s += shd_m[i] * hist_m[i];
    return clamp16(s);
  endfunction

  task automatic check(longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: y_out=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(logic r, logic signed [15:0] x, logic we, int a,
                      logic signed [15:0] d, logic cm);
    rst = r; x_in = x; cw_en = we; cw_addr = AW'(a); cw_data = d; cw_commit = cm;
    @(posedge clk);
    if (r) begin
      exp_y = 0;
      for (int i = 0; i < N; i++) begin stg_m[i] = 0; shd_m[i] = 0; hist_m[i] = 0; end
    end else begin
      exp_y = conv();
      for (int i = N - 1; i > 0; i--) hist_m[i] = hist_m[i-1];
      hist_m[0] = x;
      if (cm) for (int i = 0; i < N; i++) shd_m[i] = stg_m[i];
      if (we) stg_m[a] = d;
    end
    #1;
    check(y_out, exp_y);
    @(negedge clk);
  endtask

  task automatic run(int n, logic signed [15:0] x);
    for (int k = 0; k < n; k++) step(0, x, 0, 0, 0, 0);
  endtask

  task automatic run_rand(int n);
    for (int k = 0; k < n; k++) step(0, 16'($urandom), 0, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    tag = "R1";
    for (int k = 0; k < 4; k++) step(1, 16'sd1000, 1, k, 16'sd77, 1);
    run(N + 2, 16'sd500);

    tag = "R3";
    for (int i = 0; i < N; i++) step(0, 16'($urandom), 1, i, 16'(($urandom % 2001) - 1000), 0);
    run_rand(N + 4);

    tag = "R7";
    step(0, 16'sd0, 0, 0, 0, 1);
    run(N + 1, 16'sd0);
    step(0, 16'sd1, 0, 0, 0, 0);
    run(N + 3, 16'sd0);
    tag = "R2";
    run_rand(3 * N);

    tag = "R4";
    for (int i = N - 1; i >= 0; i--) step(0, 16'($urandom), 1, i, 16'(($urandom % 4001) - 2000), 0);
    run_rand(5);
    tag = "R9";
    step(0, 16'($urandom), 0, 0, 0, 1);
    run_rand(2 * N);

    tag = "R8";
    step(0, 16'($urandom), 1, 0, 16'sd3333, 1);
    run_rand(N + 2);
    step(0, 16'($urandom), 0, 0, 0, 1);
    run_rand(N + 2);

    tag = "R5";
    for (int i = 0; i < N; i++) step(0, 16'sd0, 1, i, 16'sd32767, 0);
    step(0, 16'sd0, 0, 0, 0, 1);
    run(N + 3, 16'sd32767);
    tag = "R6";
    run(N + 3, -16'sd32768);

    tag = "R4";
    for (int r = 0; r < 30; r++) begin
      for (int k = 0; k < 8; k++)
        step(0, 16'($urandom), ($urandom % 2) == 1, int'($urandom % N),
             16'($urandom), ($urandom % 10) == 0);
    end
    run_rand(N + 2);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule